// File: doc/BRIEF.md
# Three-Phase Sawtooth PWM with Dead-Time

This block produces the six gate-drive signals of a three-phase half-bridge inverter. A single free-running up-counter forms a shared sawtooth; each of the three phase legs compares its duty word with that sawtooth. The result drives the upper switch of the leg. The lower switch is driven from a second compare window on the same sawtooth. That window is narrowed by a dead-time margin on both sides, so the lower switch turns on only some counts after the upper one has turned off, and it turns off again some counts before the upper one turns back on.

Duty words are captured into per-leg shadow registers only at the sawtooth wrap, or at any time while the block is idle. A change that arrives mid-period therefore never produces a partial pulse. A one-cycle strobe marks the sawtooth peak and can be used to time duty updates. The dead-time margin is a design parameter in counter ticks.

Top module: `tri_pwm_dt`

## Requirements
- R1: While enabled, the sawtooth advances by one every clock, runs from 0 to 1023 (10-bit), and returns to 0 on the clock after 1023; the first enabled cycle sees count 0.
- R2: A leg's upper output `hi_gate[i]` is 1 exactly while count < captured duty; duty 0 keeps it off, duty 1023 keeps it on for 1023 of every 1024 counts.
- R3: A leg's lower output `lo_gate[i]` is 1 exactly while duty + DT ≤ count ≤ 1023 − DT (DT = 8 by default), with duty + DT saturating at 1023, so the lower output stays off for any duty above 1023 − 2·DT.
- R4: No leg ever has `hi_gate[i]` and `lo_gate[i]` both at 1, and every rising edge of either output of a leg is preceded by at least DT clocks during which the other output of that leg was 0.
- R5: `peak_stb` is 1 for exactly the one clock in which count is 1023, once per 1024-clock period, and 0 otherwise.
- R6: Duty inputs take effect only at the wrap from 1023 to 0 or while disabled; a change made mid-period leaves the outputs unchanged until the next period begins.
- R7: While `en` is 0, all six gate outputs and `peak_stb` are 0 and the counter is held at 0, so the first strobe after enabling comes on the 1024th enabled clock.
- R8: Driving `rst_n` low forces all seven outputs to 0 at once, without waiting for a clock edge; release is synchronised to `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on the clock |
| en | input | 1 | Run enable; low idles the block with all outputs off |
| duty_a | input | 10 | Duty word for leg A |
| duty_b | input | 10 | Duty word for leg B |
| duty_c | input | 10 | Duty word for leg C |
| hi_gate | output | 3 | Upper-switch drive, bit i = leg i (A=0, B=1, C=2) |
| lo_gate | output | 3 | Lower-switch drive, bit i = leg i |
| peak_stb | output | 1 | One-clock pulse at the sawtooth maximum |

## Verification
A counter that slips or wraps at the wrong value shows up within one period as a strobe off its 1024-clock spacing and as gate edges at shifted counts. A shadow register loaded at the wrong moment shows as a pulse width that changes mid-period, which a mid-period duty change exposes within the same period. A wrong dead-time threshold shows as overlapping gates or as a lower-output edge closer than DT clocks to an upper-output edge. Every such error is visible at the gate pins at the next edge of the affected leg.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int unsigned NUM_LEGS = 3;

  // saturating add of a margin onto a counter-wide value
  function automatic logic [15:0] sat_add(input logic [15:0] a,
                                          input logic [15:0] b,
                                          input logic [15:0] lim);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s > {1'b0, lim}) sat_add = lim;
    else sat_add = s[15:0];
  endfunction
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!active)          cnt_d = '0;
    else if (cnt_q == TOP) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign wrap = active && (cnt_q == TOP);

  // R1
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt == TOP) |=> (cnt == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0));
endmodule

// File: rtl/pwm_leg.sv
module pwm_leg
  import pwm3_pkg::*;
#(
  parameter int unsigned CW = 10,
  parameter int unsigned DT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          load,
  input  logic [CW-1:0] duty_in,
  input  logic [CW-1:0] cnt,
  output logic          hi,
  output logic          lo
);
  localparam logic [CW-1:0] TOP    = {CW{1'b1}};
  localparam logic [CW-1:0] DT_V   = CW'(DT);
  localparam logic [CW-1:0] LO_END = TOP - DT_V;

  logic [CW-1:0] shadow_q, shadow_d;
  logic [CW-1:0] lo_start;

  always_comb begin
    shadow_d = shadow_q;
    if (load) shadow_d = duty_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= shadow_d;
  end

  assign lo_start = CW'(sat_add(16'(shadow_q), 16'(DT_V), 16'(TOP)));

  assign hi = active && (cnt < shadow_q);
  assign lo = active && (cnt >= lo_start) && (cnt <= LO_END);

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi && lo));

  // R4
  lo_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo) |-> !$past(hi));

  // R4
  hi_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi) |-> !$past(lo));

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt != TOP) |=> $stable(shadow_q));
endmodule

// File: rtl/tri_pwm_dt.sv
module tri_pwm_dt
  import pwm3_pkg::*;
#(
  parameter int unsigned CW = 10,
  parameter int unsigned DT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] duty_a,
  input  logic [CW-1:0] duty_b,
  input  logic [CW-1:0] duty_c,
  output logic [2:0]    hi_gate,
  output logic [2:0]    lo_gate,
  output logic          peak_stb
);
  logic          srst_n;
  logic          active;
  logic [CW-1:0] cnt;
  logic          wrap;
  logic          load;
  logic [CW-1:0] duty_v [NUM_LEGS];

  pwm_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign active = en && srst_n;

  pwm_ramp #(.CW(CW)) u_ramp (
    .clk    (clk),
    .rst_n  (srst_n),
    .active (active),
    .cnt    (cnt),
    .wrap   (wrap)
  );

  assign load      = !active || wrap;
  assign duty_v[0] = duty_a;
  assign duty_v[1] = duty_b;
  assign duty_v[2] = duty_c;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    pwm_leg #(.CW(CW), .DT(DT)) u_leg (
      .clk     (clk),
      .rst_n   (srst_n),
      .active  (active),
      .load    (load),
      .duty_in (duty_v[g]),
      .cnt     (cnt),
      .hi      (hi_gate[g]),
      .lo      (lo_gate[g])
    );
  end

  assign peak_stb = wrap;

  // R5
  single_peak_chk: assert property (@(posedge clk) disable iff (!srst_n)
    peak_stb |=> !peak_stb);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !en |-> (hi_gate == 3'b000 && lo_gate == 3'b000 && !peak_stb));
endmodule

// File: tb/tri_pwm_dt_test.sv
module tri_pwm_dt_test;
  localparam int DT  = 8;
  localparam int TOP = 1023;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [9:0] duty_a, duty_b, duty_c;
  logic [2:0] hi_gate, lo_gate;
  logic       peak_stb;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  bit done   = 1'b0;

  int mc;
  int ms [3];
  int hi_age [3];
  int lo_age [3];
  logic [2:0] hi_prev, lo_prev;

  always #5 clk = ~clk;

  tri_pwm_dt uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c),
    .hi_gate(hi_gate), .lo_gate(lo_gate), .peak_stb(peak_stb)
  );

  function automatic int duty_of(input int i);
    case (i)
      0: duty_of = duty_a;
      1: duty_of = duty_b;
      default: duty_of = duty_c;
    endcase
  endfunction

  // reference model built from R1, R6, R7
  always @(posedge clk) begin
    if (!en || mc == TOP) begin
      mc <= en ? 0 : 0;
      for (int i = 0; i < 3; i++) ms[i] <= duty_of(i);
    end else begin
      mc <= mc + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (count %0d)", req, act, exp_v, mc);
    end
  endtask

  // per-cycle comparison against the model and dead-time monitor
  always @(negedge clk) begin
    if (chk_on) begin
      for (int i = 0; i < 3; i++) begin
        int st;
        int eh, el;
        st = ms[i] + DT;
        if (st > TOP) st = TOP;
        eh = (en && mc < ms[i]) ? 1 : 0;
        el = (en && mc >= st && mc <= TOP - DT) ? 1 : 0;
        check("R2 hi_gate", int'(hi_gate[i]), eh);
        check("R3 lo_gate", int'(lo_gate[i]), el);
        check("R4 overlap", int'(hi_gate[i] & lo_gate[i]), 0);
        if (lo_gate[i] && !lo_prev[i]) check("R4 lo gap", int'(hi_age[i] >= DT), 1);
        if (hi_gate[i] && !hi_prev[i]) check("R4 hi gap", int'(lo_age[i] >= DT), 1);
        hi_age[i] = hi_gate[i] ? 0 : hi_age[i] + 1;
        lo_age[i] = lo_gate[i] ? 0 : lo_age[i] + 1;
      end
      check("R5 peak_stb", int'(peak_stb), (en && mc == TOP) ? 1 : 0);
    end else begin
      for (int i = 0; i < 3; i++) begin
        hi_age[i] = 4096;
        lo_age[i] = 4096;
      end
    end
    hi_prev = hi_gate;
    lo_prev = lo_gate;
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #2;
  endtask

  task automatic wait_count(input int c);
    do step(1); while (mc != c);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; en = 1'b0;
    duty_a = 10'd100; duty_b = 10'd500; duty_c = 10'd900;
    step(3);
    check("R8 reset hi", int'(hi_gate), 0);
    check("R8 reset lo", int'(lo_gate), 0);
    check("R8 reset stb", int'(peak_stb), 0);
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic t_idle;
    chk_on = 1'b1;
    en = 1'b0;
    for (int k = 0; k < 20; k++) begin
      duty_a = 10'(k * 50); duty_b = 10'(1023 - k); duty_c = 10'(k);
      step(1);
      check("R7 idle hi", int'(hi_gate), 0);
      check("R7 idle lo", int'(lo_gate), 0);
      check("R7 idle stb", int'(peak_stb), 0);
    end
  endtask

  task automatic t_first_strobe;
    int n;
    duty_a = 10'd100; duty_b = 10'd512; duty_c = 10'd900;
    step(1);
    en = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!peak_stb && n < 2000);
    check("R7 first strobe clock", n, 1024);
    step(1);
  endtask

  task automatic t_run(input int a, input int b, input int c, input int periods);
    duty_a = 10'(a); duty_b = 10'(b); duty_c = 10'(c);
    en = 1'b1;
    wait_count(0);
    step(1024 * periods);
  endtask

  task automatic t_strobe_spacing;
    int n;
    en = 1'b1;
    @(negedge clk);
    while (!peak_stb) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!peak_stb && n < 2000);
    check("R5 strobe spacing", n, 1024);
    step(1);
  endtask

  task automatic t_mid_change;
    duty_a = 10'd300; duty_b = 10'd300; duty_c = 10'd300;
    wait_count(0);
    wait_count(200);
    duty_a = 10'd700;
    wait_count(500);
    @(negedge clk);
    check("R6 old duty kept hi", int'(hi_gate[0]), 0);
    check("R6 old duty kept lo", int'(lo_gate[0]), 1);
    step(1);
    wait_count(500);
    @(negedge clk);
    check("R6 new duty hi", int'(hi_gate[0]), 1);
    step(1);
  endtask

  task automatic t_async_reset;
    duty_a = 10'd1000; duty_b = 10'd1000; duty_c = 10'd1000;
    wait_count(0);
    wait_count(10);
    chk_on = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R8 async hi", int'(hi_gate), 0);
    check("R8 async lo", int'(lo_gate), 0);
    check("R8 async stb", int'(peak_stb), 0);
    en = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(5);
    chk_on = 1'b1;
    en = 1'b1;
    step(2048);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_first_strobe();
    t_run(0, 1023, 512, 2);                          // R2 extremes
    t_run(1015, 1007, 1008, 2);                      // R3 empty and narrow windows
    t_run(1, 2, 3, 1);                               // R4 small duties
    t_strobe_spacing();                              // R5
    t_mid_change();                                  // R6
    t_async_reset();                                 // R8
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule